// File: doc/BRIEF.md
# Subcarrier Load-Modulation Bit Encoder

This block is the transmit side of a passive tag on a 13.56 MHz contactless link. It takes bytes over a valid/ready handshake and drives one modulation line. Time is divided into slots of `SLOT_CYCLES` carrier cycles. A slot whose value is 1 carries a subcarrier that is high for `SUB_HALF` cycles and low for the next `SUB_HALF` cycles, repeating. With the defaults of 256 and 32 this is eight half-periods per slot, or the carrier divided by 64. A slot whose value is 0 leaves the line quiet.

Each data bit is sent as a pair of slots, least significant bit first. A 1 is sent as quiet then modulated, and a 0 as modulated then quiet. The first accepted byte opens a frame with a fixed 8-slot opening pattern. After the byte marked last, a fixed 8-slot closing pattern ends the frame. A one-byte holding register lets the upstream logic hand over the next byte while the current one is being sent, so bytes follow each other with no gap in slot timing.

Top module: `lm_encoder`

## Requirements
- R1: After reset and while idle, `mod_out` is low and `in_ready` is high.
- R2: A byte accepted while idle starts a frame. The first slot begins in the cycle after the accepting edge, and the first 8 slots carry 0,0,0,1,1,1,0,1 (the byte 0x1D sent MSB first).
- R3: Data bits follow least significant bit first. Each bit takes two slots: a bit of 1 is sent as slot 0 then slot 1, and a bit of 0 as slot 1 then slot 0.
- R4: The slot pair of the last bit of a byte flagged by `in_last` is followed directly by 8 slots carrying 1,0,1,1,1,0,0,0 (the byte 0xB8 sent MSB first).
- R5: Every slot lasts exactly `SLOT_CYCLES` cycles. In a slot holding 1, `mod_out` is high for `SUB_HALF` cycles, then low for `SUB_HALF` cycles, and so on. The subcarrier starts high again at the first cycle of every slot.
- R6: In a slot holding 0, `mod_out` stays low for the whole slot.
- R7: Within a frame, `in_ready` is high only while the holding register is empty, no last byte has been accepted and the closing pattern is not being sent. It is low in the cycle after any accepting edge. A byte accepted before the current byte's final slot ends is sent with no gap.
- R8: If the current byte is not flagged last and no next byte is held when its final slot ends, the closing pattern follows immediately.
- R9: In the cycle after the last closing slot ends, the block is idle: `mod_out` is low and `in_ready` is high.
- R10: `in_valid` asserted while `in_ready` is low has no effect. The data and last flag presented are not stored and do not change the slots sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte offered on `in_data` |
| in_data | input | 8 | Byte to send, LSB goes first |
| in_last | input | 1 | Marks the final byte of the frame |
| in_ready | output | 1 | Byte is taken at an edge where valid and ready are both high |
| mod_out | output | 1 | Load-modulation line |

## Verification
The bench builds the encoder with `SLOT_CYCLES` = 64 and `SUB_HALF` = 8. This keeps eight half-periods per slot, as the defaults give, and selects the power-of-two subcarrier tap. Slots are four times shorter than with the defaults, so frames of up to four bytes fit in the run many times over. These include frames with random hand-over delays that reach close to the end of the current byte, an underrun frame, and a burst of ignored offers during the opening pattern. Every cycle of every slot is compared against a model built from the pattern bytes and the bit-pair rule.

// File: rtl/lm_enc_pkg.sv
package lm_enc_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);
    localparam int PAT_W     = 8;
    localparam int PAT_IDX_W = $clog2(PAT_W);

    localparam logic [PAT_W-1:0] OPEN_PAT_DEF  = 8'h1D;
    localparam logic [PAT_W-1:0] CLOSE_PAT_DEF = 8'hB8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_OPEN  = 2'd1,
        PH_DATA  = 2'd2,
        PH_CLOSE = 2'd3
    } frame_phase_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              last;
    } byte_ent_t;

    typedef struct packed {
        logic [BIT_IDX_W-1:0] bit_idx;
        logic                 second;
    } sym_pos_t;

    // slot pair for one data bit: {first slot, second slot}
    function automatic logic [1:0] bit_to_pair(input logic b);
        return b ? 2'b01 : 2'b10;
    endfunction

    // pattern slot, most significant bit first
    function automatic logic pattern_slot(input logic [PAT_W-1:0] pat,
                                          input logic [PAT_IDX_W-1:0] idx);
        logic [PAT_IDX_W-1:0] pos;
        pos = PAT_IDX_W'(PAT_W - 1) - idx;
        return pat[pos];
    endfunction

endpackage

// File: rtl/lm_slot_timer.sv
module lm_slot_timer #(
    parameter int SLOT_CYCLES = 256,
    parameter int SUB_HALF    = 32,
    localparam int CNT_W      = $clog2(SLOT_CYCLES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    output logic [CNT_W-1:0] slot_cnt,
    output logic             slot_end,
    output logic             sc_on
);
    localparam int  HALF_LOG  = $clog2(SUB_HALF);
    localparam bit  HALF_POW2 = (SUB_HALF & (SUB_HALF - 1)) == 0;

    logic [CNT_W-1:0] cnt_q;

    assign slot_cnt = cnt_q;
    assign slot_end = run && (cnt_q == CNT_W'(SLOT_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || slot_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (HALF_POW2) begin : g_tap
            // half-period index parity taken straight from the slot counter
            assign sc_on = ~cnt_q[HALF_LOG];
        end else begin : g_div
            localparam int SUB_W = (HALF_LOG < 1) ? 1 : HALF_LOG;
            logic [SUB_W-1:0] sub_q;
            logic             on_q;
            always_ff @(posedge clk) begin
                if (rst || !run || slot_end) begin
                    sub_q <= '0;
                    on_q  <= 1'b1;
                end else if (sub_q == SUB_W'(SUB_HALF - 1)) begin
                    sub_q <= '0;
                    on_q  <= ~on_q;
                end else begin
                    sub_q <= sub_q + 1'b1;
                end
            end
            assign sc_on = on_q;
        end
    endgenerate

endmodule

// File: rtl/lm_frame_seq.sv
module lm_frame_seq
    import lm_enc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [BYTE_W-1:0]    in_data,
    input  logic                 in_last,
    input  logic                 slot_end,
    output logic                 in_ready,
    output frame_phase_e         phase,
    output logic [PAT_IDX_W-1:0] pat_idx,
    output logic                 data_bit,
    output logic                 second_half
);
    frame_phase_e         phase_q;
    logic [PAT_IDX_W-1:0] pat_q;
    byte_ent_t            hold_q;
    logic                 hold_v;
    byte_ent_t            cur_q;
    sym_pos_t             pos_q;
    logic                 last_taken;

    logic take, pat_done, byte_done, load_cur;

    assign in_ready  = (phase_q == PH_IDLE) ||
                       ((phase_q != PH_CLOSE) && !hold_v && !last_taken);
    assign take      = in_valid && in_ready;
    assign pat_done  = slot_end && (pat_q == PAT_IDX_W'(PAT_W - 1));
    assign byte_done = slot_end && (phase_q == PH_DATA) && pos_q.second &&
                       (pos_q.bit_idx == BIT_IDX_W'(BYTE_W - 1));
    assign load_cur  = ((phase_q == PH_OPEN) && pat_done) ||
                       (byte_done && !cur_q.last && hold_v);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            pat_q      <= '0;
            hold_q     <= '0;
            hold_v     <= 1'b0;
            cur_q      <= '0;
            pos_q      <= '0;
            last_taken <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (take) begin
                        phase_q <= PH_OPEN;
                        pat_q   <= '0;
                    end
                end
                PH_OPEN: begin
                    if (pat_done) begin
                        phase_q <= PH_DATA;
                        pat_q   <= '0;
                    end else if (slot_end) begin
                        pat_q <= pat_q + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (slot_end) begin
                        if (!pos_q.second) begin
                            pos_q.second <= 1'b1;
                        end else begin
                            pos_q.second  <= 1'b0;
                            pos_q.bit_idx <= pos_q.bit_idx + 1'b1;
                            cur_q.data    <= cur_q.data >> 1;
                        end
                    end
                    if (byte_done && (cur_q.last || !hold_v)) begin
                        phase_q <= PH_CLOSE;
                        pat_q   <= '0;
                    end
                end
                PH_CLOSE: begin
                    if (pat_done) begin
                        // a byte taken at the underrun edge opens a new frame
                        phase_q    <= hold_v ? PH_OPEN : PH_IDLE;
                        pat_q      <= '0;
                        last_taken <= hold_v && hold_q.last;
                    end else if (slot_end) begin
                        pat_q <= pat_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase

            if (take) begin
                hold_q.data <= in_data;
                hold_q.last <= in_last;
                hold_v      <= 1'b1;
                if (in_last) begin
                    last_taken <= 1'b1;
                end
            end

            if (load_cur) begin
                cur_q  <= hold_q;
                hold_v <= 1'b0;
                pos_q  <= '0;
            end
        end
    end

    assign phase       = phase_q;
    assign pat_idx     = pat_q;
    assign data_bit    = cur_q.data[0];
    assign second_half = pos_q.second;

endmodule

// File: rtl/lm_slot_source.sv
module lm_slot_source
    import lm_enc_pkg::*;
#(
    parameter logic [PAT_W-1:0] OPEN_PAT  = OPEN_PAT_DEF,
    parameter logic [PAT_W-1:0] CLOSE_PAT = CLOSE_PAT_DEF
) (
    input  frame_phase_e         phase,
    input  logic [PAT_IDX_W-1:0] pat_idx,
    input  logic                 data_bit,
    input  logic                 second_half,
    output logic                 slot_val
);
    logic [1:0] pair;

    always_comb begin
        pair = bit_to_pair(data_bit);
        case (phase)
            PH_OPEN:  slot_val = pattern_slot(OPEN_PAT, pat_idx);
            PH_CLOSE: slot_val = pattern_slot(CLOSE_PAT, pat_idx);
            PH_DATA:  slot_val = second_half ? pair[0] : pair[1];
            default:  slot_val = 1'b0;
        endcase
    end

endmodule

// File: rtl/lm_encoder.sv
module lm_encoder
    import lm_enc_pkg::*;
#(
    parameter int               SLOT_CYCLES = 256,
    parameter int               SUB_HALF    = 32,
    parameter logic [PAT_W-1:0] OPEN_PAT    = OPEN_PAT_DEF,
    parameter logic [PAT_W-1:0] CLOSE_PAT   = CLOSE_PAT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              mod_out
);
    localparam int CNT_W = $clog2(SLOT_CYCLES);

    frame_phase_e         seq_phase;
    logic [PAT_IDX_W-1:0] seq_pat;
    logic                 seq_bit;
    logic                 seq_second;
    logic                 seq_busy;
    logic [CNT_W-1:0]     slot_cnt;
    logic                 slot_end;
    logic                 sc_on;
    logic                 slot_val;

    assign seq_busy = (seq_phase != PH_IDLE);

    lm_slot_timer #(
        .SLOT_CYCLES (SLOT_CYCLES),
        .SUB_HALF    (SUB_HALF)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (seq_busy),
        .slot_cnt (slot_cnt),
        .slot_end (slot_end),
        .sc_on    (sc_on)
    );

    lm_frame_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_last     (in_last),
        .slot_end    (slot_end),
        .in_ready    (in_ready),
        .phase       (seq_phase),
        .pat_idx     (seq_pat),
        .data_bit    (seq_bit),
        .second_half (seq_second)
    );

    lm_slot_source #(
        .OPEN_PAT  (OPEN_PAT),
        .CLOSE_PAT (CLOSE_PAT)
    ) u_src (
        .phase       (seq_phase),
        .pat_idx     (seq_pat),
        .data_bit    (seq_bit),
        .second_half (seq_second),
        .slot_val    (slot_val)
    );

    assign mod_out = seq_busy && slot_val && sc_on;

endmodule

// File: rtl/lm_encoder_chk.sv
module lm_encoder_chk #(
    parameter int SLOT_CYCLES = 256,
    parameter int SUB_HALF    = 32,
    localparam int CNT_W      = $clog2(SLOT_CYCLES)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             mod_out,
    input logic             busy,
    input logic [CNT_W-1:0] slot_cnt,
    input logic             slot_val
);
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mod_out && in_ready)); // R1

    AST_SLOT_BEGINS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (slot_cnt == '0)); // R2

    AST_SLOT_STEADY: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (slot_cnt != '0)) |-> $stable(slot_val)); // R5

    AST_EDGE_ON_HALF: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (mod_out != $past(mod_out)))
            |-> ((int'(slot_cnt) % SUB_HALF) == 0)); // R5

    AST_TAKE_THEN_BLOCK: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && in_ready) |-> !in_ready); // R7

    AST_FRAME_CLOSE_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (in_ready && !mod_out)); // R9

endmodule

bind lm_encoder lm_encoder_chk #(
    .SLOT_CYCLES (SLOT_CYCLES),
    .SUB_HALF    (SUB_HALF)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .mod_out  (mod_out),
    .busy     (seq_busy),
    .slot_cnt (slot_cnt),
    .slot_val (slot_val)
);

// File: tb/sim_lm_encoder.sv
module sim_lm_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int SLOT       = 64;
    localparam int HALF       = 8;
    localparam int MAX_BYTES  = 4;
    localparam int WATCHDOG   = 190000;
    localparam logic [7:0] OPEN_B  = 8'h1D;
    localparam logic [7:0] CLOSE_B = 8'hB8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       mod_out;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lm_encoder #(.SLOT_CYCLES(SLOT), .SUB_HALF(HALF)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .mod_out(mod_out)
    );

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] fr_data [MAX_BYTES];
    int         fr_n;
    bit         fr_by_last;
    bit         fr_junk;
    bit         fr_gaps;
    bit         exp_slot [$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void build_slots();
        exp_slot.delete();
        for (int i = 7; i >= 0; i--) exp_slot.push_back(OPEN_B[i]);
        for (int k = 0; k < fr_n; k++) begin
            for (int b = 0; b < 8; b++) begin
                exp_slot.push_back(!fr_data[k][b]);
                exp_slot.push_back(fr_data[k][b]);
            end
        end
        for (int i = 7; i >= 0; i--) exp_slot.push_back(CLOSE_B[i]);
    endfunction

    function automatic bit exp_level(input bit s, input int c);
        return s && (((c / HALF) % 2) == 0);
    endfunction

    task automatic drive_frame();
        for (int i = 0; i < fr_n; i++) begin
            if (i > 0) begin
                do @(negedge clk); while (!in_ready);
                if (fr_gaps) repeat ($urandom_range(0, 900)) @(posedge clk);
            end
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_data  = fr_data[i];
            in_last  = (i == fr_n - 1) && fr_by_last;
            do @(negedge clk); while (!in_ready);
            @(posedge clk); #1;
            in_valid = 1'b0;
            in_data  = 8'($urandom);
            in_last  = 1'b0;
            @(negedge clk);
            check(in_ready == 1'b0, "R7", "ready after accept", int'(in_ready), 0);
            if (i == 0 && fr_junk) begin
                bit seen_ready = 1'b0;
                for (int j = 0; j < 20; j++) begin
                    @(posedge clk); #1;
                    in_valid = 1'b1;
                    in_data  = ~fr_data[0];
                    in_last  = 1'b1;
                    @(negedge clk);
                    if (in_ready) seen_ready = 1'b1;
                end
                @(posedge clk); #1;
                in_valid = 1'b0;
                in_last  = 1'b0;
                check(!seen_ready, "R10", "ready during ignored offers",
                      int'(seen_ready), 0);
            end
        end
    endtask

    task automatic check_frame();
        int nslots;
        do @(negedge clk); while (!(in_valid && in_ready));
        nslots = exp_slot.size();
        for (int s = 0; s < nslots; s++) begin
            bit    bad = 1'b0;
            int    bad_c = 0;
            bit    bad_got = 1'b0;
            bit    bad_exp = 1'b0;
            string req;
            if (s < 8) req = "R2";
            else if (s >= nslots - 8) req = fr_by_last ? "R4" : "R8";
            else req = "R3";
            req = {req, exp_slot[s] ? " R5" : " R6"};
            for (int c = 0; c < SLOT; c++) begin
                @(negedge clk);
                if (!bad && (mod_out !== exp_level(exp_slot[s], c))) begin
                    bad     = 1'b1;
                    bad_c   = c;
                    bad_got = mod_out;
                    bad_exp = exp_level(exp_slot[s], c);
                end
            end
            check(!bad, req, $sformatf("slot %0d cycle %0d mod_out", s, bad_c),
                  int'(bad_got), int'(bad_exp));
        end
        @(negedge clk);
        check(mod_out == 1'b0, "R9", "mod_out after close", int'(mod_out), 0);
        check(in_ready == 1'b1, "R9", "ready after close", int'(in_ready), 1);
    endtask

    task automatic run_frame();
        build_slots();
        fork
            drive_frame();
            check_frame();
        join
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED0B17));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(mod_out == 1'b0, "R1", "mod_out after reset", int'(mod_out), 0);
        check(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
        repeat (5) @(negedge clk);
        check(mod_out == 1'b0 && in_ready == 1'b1, "R1", "idle hold",
              int'({mod_out, in_ready}), 1);

        // R3: all-zero and all-one bytes
        fr_by_last = 1; fr_junk = 0; fr_gaps = 0;
        fr_n = 1; fr_data[0] = 8'h00; run_frame();
        fr_n = 1; fr_data[0] = 8'hFF; run_frame();
        // R7: back-to-back bytes
        fr_n = 2; fr_data[0] = 8'hA5; fr_data[1] = 8'h3C; run_frame();
        // R10: offers while ready is low
        fr_junk = 1;
        fr_n = 2; fr_data[0] = 8'h5A; fr_data[1] = 8'h81; run_frame();
        fr_junk = 0;
        // R8: underrun closes the frame
        fr_by_last = 0;
        fr_n = 1; fr_data[0] = 8'hC3; run_frame();
        fr_n = 3; fr_data[0] = 8'h01; fr_data[1] = 8'h80; fr_data[2] = 8'h7E;
        fr_gaps = 1; run_frame();

        // random frames with random hand-over delays
        for (int f = 0; f < 12; f++) begin
            fr_n       = $urandom_range(1, MAX_BYTES);
            fr_by_last = ($urandom_range(0, 4) != 0);
            fr_gaps    = 1;
            for (int k = 0; k < MAX_BYTES; k++) fr_data[k] = 8'($urandom);
            run_frame();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule